// File: doc/BRIEF.md
# NAND Block-Lock and Event Interrupt Controller

This block is the control slice of a NAND flash controller. It holds a 32-bit control word with these fields:

- two chip-select override bits;
- the direction bit for the 4-bit ECC engine;
- a soft lock bit and a sticky lock-tight bit;
- the interrupt enable bits.

It also holds a protected block window, given by a start block and an end block.

Every program or erase command passes through the block before it reaches the flash. While locking is active, a command whose block address lies inside the window is not issued, and an illegal-access event is recorded instead. Read-type commands always pass.

The block also watches the flash ready/busy line through a synchronizer. It records an event on the edge that software selects. It records the completion pulses of the ECC encoder and decoder as well. Each event sets a sticky status bit. The single interrupt line is the OR of the enabled status bits.

Software reaches the four registers through a word-addressed read/write port. Read data comes back one cycle after the address.

Top module: `nand_guard_ctrl`

## Requirements
- R1: After reset the control word reads 0x00C10000, `nce_n` is 2'b11, the status word reads 0, both window registers read 0 and `irq` is 0.
- R2: Word address 0 selects the control word, 1 the status word, 2 the window start block and 3 the window end block. `reg_rdata` shows the addressed register one cycle after `reg_addr` is presented. Only control bits 23, 22, 18, 17, 16, 13, 12, 10, 9 and 8 can be written. All other bits of the control word read as 0.
- R3: `nce_n[1]` follows control bit 23 and `nce_n[0]` follows control bit 22, where 0 selects the chip (drives it low). `ecc_encode` follows control bit 18, where 1 means encode and 0 means decode.
- R4: Control bit 16 is the soft lock. Software can set it or clear it with any write.
- R5: Locking is active when bit 16 or bit 17 is set. A command with `cmd_pe`=1 is blocked when locking is active and start ≤ `cmd_blk` < end. A blocked command gives no `cmd_out_valid`, and status bit 1 is set on the next clock edge. A command that is not blocked appears on `cmd_out_*` one cycle later with the same block and kind.
- R6: A command with `cmd_pe`=0 is always issued, whatever the lock state and the window.
- R7: The status bits are bit 0 for ready/busy, bit 1 for illegal access, bit 2 for encode done and bit 3 for decode done. Each bit stays set until software writes 1 to it at address 1. Writing 0 to a bit leaves it unchanged.
- R8: `irq` is asserted one cycle after any status bit is set while its enable is set. The enables are control bit 9 for ready/busy, bit 10 for illegal access, bit 13 for encode done and bit 12 for decode done.
- R9: `rdy_busy_in` passes through a two-flop synchronizer. Control bit 8 selects the edge that sets status bit 0: 0 selects rising and 1 selects falling. The other edge has no effect.
- R10: A one-cycle pulse on `ecc_enc_done` sets status bit 2, and a pulse on `ecc_dec_done` sets status bit 3.
- R11: Once control bit 17 is written as 1, it stays 1 until reset. While it is set, writes to the start and end registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| cmd_valid | input | 1 | Incoming command valid |
| cmd_pe | input | 1 | Command is a program or an erase |
| cmd_blk | input | BLK_W | Target block of the command |
| cmd_out_valid | output | 1 | Command issued to the flash |
| cmd_out_pe | output | 1 | Kind of the issued command |
| cmd_out_blk | output | BLK_W | Block of the issued command |
| ecc_enc_done | input | 1 | Encoder completion pulse |
| ecc_dec_done | input | 1 | Decoder completion pulse |
| rdy_busy_in | input | 1 | Asynchronous flash ready/busy line |
| nce_n | output | 2 | Chip-select overrides, active low |
| ecc_encode | output | 1 | ECC direction, 1 means encode |
| irq | output | 1 | Interrupt request |

## Verification
The bench attacks the window bounds: the start block, the end block, the block just below the start, and an empty window where start equals end. An off-by-one compare would either pass a block it should stop or stop a block it should pass.

It then writes 0 to the lock-tight bit and then tries to move the window. A design that lets the bit clear, or lets the window move, would issue a command that ought to be blocked.

It drives the ready/busy edge that is not selected before the edge that is selected. A detector wired to the wrong edge, or to both edges, would record the wrong one.

Status bits are given partial write-1-to-clear writes with enables off. A non-sticky status bit, or an interrupt that ignores its enable, would show up at the ports.

// File: rtl/nlk_pkg.sv
package nlk_pkg;
  // control word field positions
  localparam int CW_CS_HI   = 23;
  localparam int CW_CS_LO   = 22;
  localparam int CW_ECC_DIR = 18;
  localparam int CW_TIGHT   = 17;
  localparam int CW_SOFT    = 16;
  localparam int CW_EN_ENC  = 13;
  localparam int CW_EN_DEC  = 12;
  localparam int CW_EN_ILL  = 10;
  localparam int CW_EN_RB   = 9;
  localparam int CW_RB_FALL = 8;

  localparam logic [31:0] CW_RESET = 32'h00C1_0000;
  localparam logic [31:0] CW_WMASK = 32'h00C7_3700;

  typedef enum logic [1:0] {
    RA_CTRL  = 2'd0,
    RA_STAT  = 2'd1,
    RA_START = 2'd2,
    RA_END   = 2'd3
  } reg_sel_e;

  // status bit positions
  localparam int NSRC   = 4;
  localparam int ST_RB  = 0;
  localparam int ST_ILL = 1;
  localparam int ST_ENC = 2;
  localparam int ST_DEC = 3;
endpackage

// File: rtl/nlk_rb_edge.sv
module nlk_rb_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rb_async,
  input  logic fall_sel,
  output logic edge_hit
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   rb_s;

  assign rb_s = sync_q[SYNC_STAGES-1];

  // idle level of the line is high (ready)
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= '1;
      prev_q   <= 1'b1;
      edge_hit <= 1'b0;
    end else begin
      sync_q   <= {sync_q[SYNC_STAGES-2:0], rb_async};
      prev_q   <= rb_s;
      edge_hit <= fall_sel ? (prev_q & ~rb_s) : (~prev_q & rb_s);
    end
  end
endmodule

// File: rtl/nlk_win_gate.sv
module nlk_win_gate #(
  parameter int BLK_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic             cmd_pe,
  input  logic [BLK_W-1:0] cmd_blk,
  input  logic             lock_act,
  input  logic [BLK_W-1:0] win_start,
  input  logic [BLK_W-1:0] win_end,
  output logic             out_valid,
  output logic             out_pe,
  output logic [BLK_W-1:0] out_blk,
  output logic             illegal
);
  logic in_win;
  logic hit;

  assign in_win = (cmd_blk >= win_start) && (cmd_blk < win_end);
  assign hit    = cmd_valid && cmd_pe && lock_act && in_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_pe    <= 1'b0;
      out_blk   <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= cmd_valid && !hit;
      illegal   <= hit;
      if (cmd_valid && !hit) begin
        out_pe  <= cmd_pe;
        out_blk <= cmd_blk;
      end
    end
  end
endmodule

// File: rtl/nlk_irq_stat.sv
module nlk_irq_stat #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] set_vec,
  input  logic            clr_we,
  input  logic [NSRC-1:0] clr_vec,
  input  logic [NSRC-1:0] en_vec,
  output logic [NSRC-1:0] stat,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
      irq  <= 1'b0;
    end else begin
      // a new event wins over a clear in the same cycle
      stat <= (stat & ~(clr_we ? clr_vec : '0)) | set_vec;
      irq  <= |(stat & en_vec);
    end
  end
endmodule

// File: rtl/nand_guard_ctrl.sv
module nand_guard_ctrl
  import nlk_pkg::*;
#(
  parameter int BLK_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             cmd_valid,
  input  logic             cmd_pe,
  input  logic [BLK_W-1:0] cmd_blk,
  output logic             cmd_out_valid,
  output logic             cmd_out_pe,
  output logic [BLK_W-1:0] cmd_out_blk,
  input  logic             ecc_enc_done,
  input  logic             ecc_dec_done,
  input  logic             rdy_busy_in,
  output logic [1:0]       nce_n,
  output logic             ecc_encode,
  output logic             irq
);
  localparam int PAD_W = 32 - BLK_W;
  localparam int SPAD  = 32 - NSRC;

  logic [31:0]      ctrl_q;
  logic [31:0]      ctrl_nx;
  logic [BLK_W-1:0] win_start;
  logic [BLK_W-1:0] win_end;
  logic             tight_q;
  logic             lock_act;
  logic             rb_edge;
  logic             illegal;
  logic [NSRC-1:0]  set_vec;
  logic [NSRC-1:0]  en_vec;
  logic [NSRC-1:0]  stat;
  logic             wr_ctrl, wr_stat, wr_start, wr_end;

  assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
  assign wr_stat  = reg_we && (reg_addr == RA_STAT);
  assign wr_start = reg_we && (reg_addr == RA_START);
  assign wr_end   = reg_we && (reg_addr == RA_END);

  assign tight_q  = ctrl_q[CW_TIGHT];
  assign lock_act = ctrl_q[CW_SOFT] | ctrl_q[CW_TIGHT];

  always_comb begin
    ctrl_nx           = reg_wdata & CW_WMASK;
    ctrl_nx[CW_TIGHT] = ctrl_q[CW_TIGHT] | reg_wdata[CW_TIGHT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= CW_RESET;
      win_start <= '0;
      win_end   <= '0;
    end else begin
      if (wr_ctrl)             ctrl_q    <= ctrl_nx;
      if (wr_start && !tight_q) win_start <= reg_wdata[BLK_W-1:0];
      if (wr_end && !tight_q)   win_end   <= reg_wdata[BLK_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_addr)
        RA_CTRL:  reg_rdata <= ctrl_q;
        RA_STAT:  reg_rdata <= {{SPAD{1'b0}}, stat};
        RA_START: reg_rdata <= {{PAD_W{1'b0}}, win_start};
        default:  reg_rdata <= {{PAD_W{1'b0}}, win_end};
      endcase
    end
  end

  assign nce_n      = {ctrl_q[CW_CS_HI], ctrl_q[CW_CS_LO]};
  assign ecc_encode = ctrl_q[CW_ECC_DIR];

  nlk_rb_edge #(.SYNC_STAGES(SYNC_STAGES)) u_rb (
    .clk      (clk),
    .rst      (rst),
    .rb_async (rdy_busy_in),
    .fall_sel (ctrl_q[CW_RB_FALL]),
    .edge_hit (rb_edge)
  );

  nlk_win_gate #(.BLK_W(BLK_W)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_pe    (cmd_pe),
    .cmd_blk   (cmd_blk),
    .lock_act  (lock_act),
    .win_start (win_start),
    .win_end   (win_end),
    .out_valid (cmd_out_valid),
    .out_pe    (cmd_out_pe),
    .out_blk   (cmd_out_blk),
    .illegal   (illegal)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[ST_RB]  = rb_edge;
    set_vec[ST_ILL] = illegal;
    set_vec[ST_ENC] = ecc_enc_done;
    set_vec[ST_DEC] = ecc_dec_done;
    en_vec          = '0;
    en_vec[ST_RB]   = ctrl_q[CW_EN_RB];
    en_vec[ST_ILL]  = ctrl_q[CW_EN_ILL];
    en_vec[ST_ENC]  = ctrl_q[CW_EN_ENC];
    en_vec[ST_DEC]  = ctrl_q[CW_EN_DEC];
  end

  nlk_irq_stat #(.NSRC(NSRC)) u_stat (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_we  (wr_stat),
    .clr_vec (reg_wdata[NSRC-1:0]),
    .en_vec  (en_vec),
    .stat    (stat),
    .irq     (irq)
  );
endmodule

// File: rtl/nlk_guard_chk.sv
module nlk_guard_chk
  import nlk_pkg::*;
#(
  parameter int BLK_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_pe,
  input logic [BLK_W-1:0] cmd_blk,
  input logic             cmd_out_valid,
  input logic [BLK_W-1:0] cmd_out_blk,
  input logic             lock_act,
  input logic             tight,
  input logic [BLK_W-1:0] win_start,
  input logic [BLK_W-1:0] win_end,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic [NSRC-1:0]  stat,
  input logic [1:0]       nce_n
);
  a_r1_cs_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (nce_n == 2'b11));

  a_r5_window_blocks: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_pe && lock_act && cmd_blk >= win_start && cmd_blk < win_end)
    |=> !cmd_out_valid);

  a_r6_read_passes: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_pe) |=> (cmd_out_valid && cmd_out_blk == $past(cmd_blk)));

  a_r7_status_sticky: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == RA_STAT) |=> ((stat & $past(stat)) == $past(stat)));

  a_r11_tight_sticky: assert property (@(posedge clk) disable iff (rst)
    tight |=> tight);

  a_r11_window_frozen: assert property (@(posedge clk) disable iff (rst)
    tight |=> ($stable(win_start) && $stable(win_end)));
endmodule

bind nand_guard_ctrl nlk_guard_chk #(.BLK_W(BLK_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cmd_valid     (cmd_valid),
  .cmd_pe        (cmd_pe),
  .cmd_blk       (cmd_blk),
  .cmd_out_valid (cmd_out_valid),
  .cmd_out_blk   (cmd_out_blk),
  .lock_act      (lock_act),
  .tight         (tight_q),
  .win_start     (win_start),
  .win_end       (win_end),
  .reg_we        (reg_we),
  .reg_addr      (reg_addr),
  .stat          (stat),
  .nce_n         (nce_n)
);

// File: tb/tb_nand_guard_ctrl.sv
`timescale 1ns/1ps
module tb_nand_guard_ctrl;
  localparam int BW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          cmd_valid = 1'b0;
  logic          cmd_pe = 1'b0;
  logic [BW-1:0] cmd_blk = '0;
  logic          cmd_out_valid, cmd_out_pe;
  logic [BW-1:0] cmd_out_blk;
  logic          ecc_enc_done = 1'b0, ecc_dec_done = 1'b0;
  logic          rdy_busy_in = 1'b1;
  logic [1:0]    nce_n;
  logic          ecc_encode, irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  nand_guard_ctrl #(.BLK_W(BW)) dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_pe(cmd_pe), .cmd_blk(cmd_blk), .cmd_out_valid(cmd_out_valid),
    .cmd_out_pe(cmd_out_pe), .cmd_out_blk(cmd_out_blk),
    .ecc_enc_done(ecc_enc_done), .ecc_dec_done(ecc_dec_done),
    .rdy_busy_in(rdy_busy_in), .nce_n(nce_n), .ecc_encode(ecc_encode),
    .irq(irq)
  );

  function automatic bit exp_block(bit lk, bit pe, int b, int s, int e);
    return lk && pe && (b >= s) && (b < e);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // sends one command, samples the issued command one cycle later
  task automatic send(bit pe, int b, output bit issued);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_pe = pe; cmd_blk = b[BW-1:0];
    @(negedge clk);
    issued = cmd_out_valid;
    if (issued && cmd_out_blk != b[BW-1:0]) check("R5 blk", 32'(cmd_out_blk), 32'(b));
    cmd_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    bit iss;
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(2'd0, d); check("R1 ctrl", d, 32'h00C1_0000);
    rd(2'd1, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 start", d, 0);
    rd(2'd3, d); check("R1 end", d, 0);
    check("R1 nce_n", 32'(nce_n), 32'd3);
    check("R1 irq", 32'(irq), 0);

    // R2 reserved bits read as zero, R3 outputs follow fields
    wr(2'd0, 32'hFFFD_FFFF);
    rd(2'd0, d); check("R2 ctrl mask", d, 32'h00C5_3700);
    check("R3 ecc_encode", 32'(ecc_encode), 1);
    wr(2'd0, 32'h0080_0000);
    check("R3 nce_n split", 32'(nce_n), 32'd2);
    check("R3 ecc decode", 32'(ecc_encode), 0);
    // R4 soft lock cleared: window does not block
    rd(2'd0, d); check("R4 soft lock clear", d, 32'h0080_0000);

    // R5 directed window bounds 10..20
    wr(2'd2, 10); wr(2'd3, 20);
    send(1'b1, 15, iss); check("R4 unlocked passes", 32'(iss), 1);
    wr(2'd0, 32'h00C1_0000); // R4 soft lock set again
    send(1'b1, 9, iss);  check("R5 below start", 32'(iss), 1);
    send(1'b1, 10, iss); check("R5 at start", 32'(iss), 0);
    send(1'b1, 19, iss); check("R5 end-1", 32'(iss), 0);
    send(1'b1, 20, iss); check("R5 at end", 32'(iss), 1);
    rd(2'd1, d); check("R5 illegal status", d, 32'h2);
    send(1'b0, 15, iss); check("R6 read in window", 32'(iss), 1);
    check("R6 kind", 32'(cmd_out_pe), 0);
    check("R8 irq off when disabled", 32'(irq), 0);
    wr(2'd1, 32'h0); rd(2'd1, d); check("R7 write 0 keeps", d, 32'h2);
    wr(2'd0, 32'h00C1_0400);
    @(negedge clk); check("R8 irq enabled", 32'(irq), 1);
    wr(2'd1, 32'h2); @(negedge clk);
    check("R8 irq drops", 32'(irq), 0);
    rd(2'd1, d); check("R7 w1c", d, 0);
    wr(2'd2, 5); wr(2'd3, 5);
    send(1'b1, 5, iss); check("R5 empty window", 32'(iss), 1);

    // R10 ECC completion events
    @(negedge clk) ecc_enc_done = 1'b1;
    @(negedge clk) ecc_enc_done = 1'b0;
    rd(2'd1, d); check("R10 enc", d, 32'h4);
    @(negedge clk) ecc_dec_done = 1'b1;
    @(negedge clk) ecc_dec_done = 1'b0;
    rd(2'd1, d); check("R10 dec", d, 32'hC);
    wr(2'd1, 32'h4); rd(2'd1, d); check("R7 partial clear", d, 32'h8);
    wr(2'd1, 32'hF);

    // R9 ready/busy edge select, rising first
    wr(2'd0, 32'h00C1_0200);
    @(negedge clk) rdy_busy_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd1, d); check("R9 falling ignored", d, 0);
    @(negedge clk) rdy_busy_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd1, d); check("R9 rising seen", d, 32'h1);
    check("R8 rb irq", 32'(irq), 1);
    wr(2'd1, 32'h1);
    wr(2'd0, 32'h00C1_0300);
    @(negedge clk) rdy_busy_in = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd1, d); check("R9 falling seen", d, 32'h1);
    wr(2'd1, 32'h1);
    @(negedge clk) rdy_busy_in = 1'b1;
    repeat (6) @(negedge clk);
    rd(2'd1, d); check("R9 rising ignored", d, 0);

    // R5 random window checks
    for (int i = 0; i < 40; i++) begin
      int s = int'($urandom % 64);
      int e = int'($urandom % 64);
      int b = int'($urandom % 80);
      bit pe = 1'($urandom % 2);
      bit sl = 1'($urandom % 2);
      bit ex;
      wr(2'd2, 32'(s)); wr(2'd3, 32'(e));
      wr(2'd0, 32'h00C0_0000 | (32'(sl) << 16));
      ex = exp_block(sl, pe, b, s, e);
      send(pe, b, iss);
      check("R5 random issue", 32'(iss), 32'(!ex));
      rd(2'd1, d); check("R5 random status", d, ex ? 32'h2 : 32'h0);
      wr(2'd1, 32'hF);
    end

    // R11 lock-tight
    wr(2'd2, 30); wr(2'd3, 40);
    wr(2'd0, 32'h00C2_0000);
    wr(2'd0, 32'h00C0_0000);
    rd(2'd0, d); check("R11 tight sticky", d, 32'h00C2_0000);
    wr(2'd2, 0); wr(2'd3, 100);
    rd(2'd2, d); check("R11 start frozen", d, 30);
    rd(2'd3, d); check("R11 end frozen", d, 40);
    send(1'b1, 35, iss); check("R11 still locked", 32'(iss), 0);
    send(1'b1, 45, iss); check("R11 outside", 32'(iss), 1);

    done = 1;
    finish_run();
  end
endmodule